// File: doc/BRIEF.md
# I/Q Sample Pair Receiver

This block sits at the input of a dual-channel converter datapath. It takes raw sample data from a parallel input port and delivers one 16-bit I sample and one 16-bit Q sample together, marked by a one-cycle valid strobe. A 2-bit width selector picks how the port is used. In the full-width setting a single 32-bit transfer carries both samples. In the half-width setting the two samples arrive one after the other on the low 16 bits. In the quarter-width setting they arrive one byte at a time on the low 8 bits.

Three run-time controls shape the stream. The first chooses whether each pair opens with I or with Q. The second mirrors the bit order of the active port lane. The third marks the input as offset binary, so that it is converted to two's complement on the way out. A frame marker realigns the assembly position. The fourth value of the width selector is illegal. It raises an error flag and suppresses all output.

Top module: `iq_pair_receiver`

## Requirements
- R1: With cfg_mode = 00 each accepted transfer carries the first sample of the pair on in_data[31:16] and the second on in_data[15:0]. The pair appears with out_valid on the cycle after that transfer.
- R2: With cfg_mode = 01 the lane is in_data[15:0] and a pair takes two accepted beats, first sample then second sample. out_valid pulses on the cycle after the second beat and stays low after the first.
- R3: With cfg_mode = 10 the lane is in_data[7:0] and a pair takes four accepted beats: first-sample high byte, first-sample low byte, second-sample high byte, second-sample low byte. out_valid pulses only after the fourth beat.
- R4: With cfg_mode = 11, mode_err is high and out_valid stays low whatever arrives. mode_err is low in every other mode.
- R5: cfg_q_first = 0 routes the first sample of a pair to out_i and the second to out_q. cfg_q_first = 1 routes the first to out_q and the second to out_i.
- R6: With cfg_swap = 1 the active lane of width W (32, 16 or 8) is mirrored before assembly: lane bit k takes in_data[W-1-k]. With cfg_swap = 0 bits pass straight through.
- R7: With cfg_binary = 1, bit 15 of each assembled sample is inverted after assembly and swapping. With cfg_binary = 0 samples pass unchanged.
- R8: A beat accepted with in_frame = 1 is taken as the first position of a new pair, and any partial pair is dropped.
- R9: A change of cfg_mode or cfg_q_first drops any partial pair. The next accepted beat, including one in the same cycle as the change, is taken as the first position.
- R10: Cycles with in_valid = 0 are ignored, whatever in_data and in_frame hold. They neither advance assembly nor produce output.
- R11: After reset, out_valid, out_i and out_q are 0, and the assembly position is the first position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mode | input | 2 | Port width select: 00 full, 01 half, 10 quarter, 11 illegal |
| cfg_q_first | input | 1 | 1 = pairs open with Q |
| cfg_swap | input | 1 | 1 = mirror the active lane bit order |
| cfg_binary | input | 1 | 1 = input is offset binary |
| in_valid | input | 1 | Beat present on in_data |
| in_frame | input | 1 | Beat is the first position of a pair |
| in_data | input | 32 | Raw input port |
| out_valid | output | 1 | One-cycle strobe for a completed pair |
| out_i | output | 16 | I sample, two's complement |
| out_q | output | 16 | Q sample, two's complement |
| mode_err | output | 1 | Width select is the illegal value |

## Verification
The hardest state to reach from the ports is a partial pair that a frame marker or a configuration change must discard. Quarter-width mode can sit at any of three partial positions, and only the later output shows whether the stale bytes were really dropped. The stimulus leaves deliberate stray beats before a framed pair, flips the ordering control and the width select between partial beats, and inserts idle cycles that carry garbage data. Every resulting pair is then compared with the value expected from the beats after the discard point.

// File: rtl/iq_pair_receiver.sv
module iq_pair_receiver #(
  parameter int SAMPLE_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [1:0]            cfg_mode,
  input  logic                  cfg_q_first,
  input  logic                  cfg_swap,
  input  logic                  cfg_binary,
  input  logic                  in_valid,
  input  logic                  in_frame,
  input  logic [2*SAMPLE_W-1:0] in_data,
  output logic                  out_valid,
  output logic [SAMPLE_W-1:0]   out_i,
  output logic [SAMPLE_W-1:0]   out_q,
  output logic                  mode_err
);
  localparam int BUS_W  = 2 * SAMPLE_W;
  localparam int BYTE_W = SAMPLE_W / 2;
  localparam logic [1:0] M_DUAL = 2'b00;
  localparam logic [1:0] M_WORD = 2'b01;
  localparam logic [1:0] M_BYTE = 2'b10;
  localparam logic [1:0] M_BAD  = 2'b11;
  localparam logic [SAMPLE_W-1:0] TOP_BIT = {1'b1, {(SAMPLE_W-1){1'b0}}};

  logic [BUS_W-1:0]    rev_bus, bus_lane;
  logic [SAMPLE_W-1:0] rev_word, word_lane;
  logic [BYTE_W-1:0]   rev_byte, byte_lane;

  always_comb begin
    for (int k = 0; k < BUS_W; k++)    rev_bus[k]  = in_data[BUS_W-1-k];
    for (int k = 0; k < SAMPLE_W; k++) rev_word[k] = in_data[SAMPLE_W-1-k];
    for (int k = 0; k < BYTE_W; k++)   rev_byte[k] = in_data[BYTE_W-1-k];
  end

  assign bus_lane  = cfg_swap ? rev_bus  : in_data;
  assign word_lane = cfg_swap ? rev_word : in_data[SAMPLE_W-1:0];
  assign byte_lane = cfg_swap ? rev_byte : in_data[BYTE_W-1:0];

  logic [1:0]          cnt, pos, last;
  logic [1:0]          prev_mode;
  logic                prev_qf;
  logic                cfg_chg, emit;
  logic [SAMPLE_W-1:0] hold_first;
  logic [BYTE_W-1:0]   hold_hi;
  logic [SAMPLE_W-1:0] first_s, second_s, fmt_mask;

  assign mode_err = (cfg_mode == M_BAD);
  assign cfg_chg  = (cfg_mode != prev_mode) || (cfg_q_first != prev_qf);
  assign pos      = (in_frame || cfg_chg) ? 2'd0 : cnt;
  assign last     = (cfg_mode == M_WORD) ? 2'd1 : (cfg_mode == M_BYTE) ? 2'd3 : 2'd0;
  assign emit     = in_valid && !mode_err && (pos == last);
  assign fmt_mask = cfg_binary ? TOP_BIT : '0;

  always_comb begin
    case (cfg_mode)
      M_DUAL: begin
        first_s  = bus_lane[BUS_W-1:SAMPLE_W];
        second_s = bus_lane[SAMPLE_W-1:0];
      end
      M_WORD: begin
        first_s  = hold_first;
        second_s = word_lane;
      end
      M_BYTE: begin
        first_s  = hold_first;
        second_s = {hold_hi, byte_lane};
      end
      default: begin
        first_s  = hold_first;
        second_s = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt        <= 2'd0;
      prev_mode  <= M_DUAL;
      prev_qf    <= 1'b0;
      hold_first <= '0;
      hold_hi    <= '0;
      out_valid  <= 1'b0;
      out_i      <= '0;
      out_q      <= '0;
    end else begin
      prev_mode <= cfg_mode;
      prev_qf   <= cfg_q_first;
      out_valid <= emit;
      if (mode_err) begin
        cnt <= 2'd0;
      end else if (in_valid) begin
        cnt <= emit ? 2'd0 : pos + 2'd1;
        if (cfg_mode == M_WORD && pos == 2'd0) hold_first <= word_lane;
        if (cfg_mode == M_BYTE) begin
          case (pos)
            2'd0:    hold_first[SAMPLE_W-1 -: BYTE_W] <= byte_lane;
            2'd1:    hold_first[BYTE_W-1:0] <= byte_lane;
            2'd2:    hold_hi <= byte_lane;
            default: ;
          endcase
        end
      end else if (cfg_chg) begin
        cnt <= 2'd0;
      end
      if (emit) begin
        out_i <= (cfg_q_first ? second_s : first_s) ^ fmt_mask;
        out_q <= (cfg_q_first ? first_s : second_s) ^ fmt_mask;
      end
    end
  end

  p_bad_mode_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode == M_BAD) |=> !out_valid);

  p_dual_every_beat_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode == M_DUAL && in_valid) |=> out_valid);

  p_idle_no_output_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  p_word_no_back_to_back_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode == M_WORD && $past(cfg_mode) == M_WORD && out_valid) |-> !$past(out_valid));

  p_byte_no_back_to_back_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode == M_BYTE && $past(cfg_mode) == M_BYTE && out_valid) |-> !$past(out_valid));
endmodule

// File: tb/iq_pair_receiver_test.sv
module iq_pair_receiver_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] cfg_mode = 2'b00;
  logic cfg_q_first = 1'b0, cfg_swap = 1'b0, cfg_binary = 1'b0;
  logic in_valid = 1'b0, in_frame = 1'b0;
  logic [31:0] in_data = '0;
  logic out_valid, mode_err;
  logic [15:0] out_i, out_q;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  iq_pair_receiver uut (.clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode),
    .cfg_q_first(cfg_q_first), .cfg_swap(cfg_swap), .cfg_binary(cfg_binary),
    .in_valid(in_valid), .in_frame(in_frame), .in_data(in_data),
    .out_valid(out_valid), .out_i(out_i), .out_q(out_q), .mode_err(mode_err));

  function automatic logic [31:0] rev32(input logic [31:0] x);
    for (int k = 0; k < 32; k++) rev32[k] = x[31-k];
  endfunction
  function automatic logic [15:0] rev16(input logic [15:0] x);
    for (int k = 0; k < 16; k++) rev16[k] = x[15-k];
  endfunction
  function automatic logic [7:0] rev8(input logic [7:0] x);
    for (int k = 0; k < 8; k++) rev8[k] = x[7-k];
  endfunction

  task automatic chk(input bit ok, input string req, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic beat(input logic [31:0] d, input bit fr);
    @(negedge clk);
    in_valid = 1'b1; in_frame = fr; in_data = d;
    @(posedge clk);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b0; in_frame = k[0]; in_data = 32'hDEAD_BEEF ^ k;
      @(posedge clk);
    end
  endtask

  task automatic quiet(input string req);
    @(negedge clk);
    chk(!out_valid, req, {47'd0, out_valid}, 48'd0);
  endtask

  // Drives beats 'from' to 3 (byte) / 1 (word) of the pair (a, b).
  task automatic send_part(input logic [15:0] a, input logic [15:0] b, input int from, input bit fr);
    logic [31:0] d;
    int last;
    last = (cfg_mode == 2'b00) ? 0 : (cfg_mode == 2'b01) ? 1 : 3;
    for (int p = from; p <= last; p++) begin
      if (cfg_mode == 2'b00) d = cfg_swap ? rev32({a, b}) : {a, b};
      else if (cfg_mode == 2'b01) d = {16'hA5A5, cfg_swap ? rev16(p == 0 ? a : b) : (p == 0 ? a : b)};
      else begin
        logic [7:0] by;
        by = (p == 0) ? a[15:8] : (p == 1) ? a[7:0] : (p == 2) ? b[15:8] : b[7:0];
        d = {24'h5A5A5A, cfg_swap ? rev8(by) : by};
      end
      if (p != from) chk(!out_valid, cfg_mode == 2'b01 ? "R2 partial" : "R3 partial", {47'd0, out_valid}, 48'd0);
      beat(d, fr && (p == from));
    end
    @(negedge clk);
    in_valid = 1'b0; in_frame = 1'b0;
  endtask

  task automatic expect_pair(input logic [15:0] a, input logic [15:0] b, input string req);
    logic [15:0] ei, eq, m;
    m = cfg_binary ? 16'h8000 : 16'h0000;
    ei = (cfg_q_first ? b : a) ^ m;
    eq = (cfg_q_first ? a : b) ^ m;
    chk(out_valid && out_i == ei && out_q == eq, req, {15'd0, out_valid, out_i, out_q}, {16'd1, ei, eq});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] a, b;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!out_valid && out_i == 0 && out_q == 0 && !mode_err, "R11 reset",
        {15'd0, out_valid, out_i, out_q}, 48'd0);
    rst_n = 1'b1;
    // R11: first beat after reset is the first position without a frame marker
    cfg_mode = 2'b01;
    idle(2);
    send_part(16'h1357, 16'h2468, 0, 1'b0);
    expect_pair(16'h1357, 16'h2468, "R11 start position");

    // Sweep: modes R1 R2 R3, orders R5, swap R6, format R7
    for (int m = 0; m < 3; m++) begin
      for (int c = 0; c < 8; c++) begin
        @(negedge clk);
        cfg_mode = m[1:0]; cfg_q_first = c[0]; cfg_swap = c[1]; cfg_binary = c[2];
        for (int p = 0; p < 6; p++) begin
          case (p)
            0: begin a = 16'h0000; b = 16'hFFFF; end
            1: begin a = 16'h8000; b = 16'h7FFF; end
            2: begin a = 16'h0001; b = 16'h8001; end
            default: begin a = 16'(p * 16'h3A97 + c * 16'h0F13 + m); b = 16'(~a + 16'h1C2D * p); end
          endcase
          send_part(a, b, 0, 1'b1);
          expect_pair(a, b, m == 0 ? "R1 R5 R6 R7 dual" : m == 1 ? "R2 R5 R6 R7 word" : "R3 R5 R6 R7 byte");
        end
      end
    end

    // R4: illegal mode
    @(negedge clk);
    cfg_mode = 2'b11; cfg_q_first = 0; cfg_swap = 0; cfg_binary = 0;
    @(negedge clk);
    chk(mode_err, "R4 flag", {47'd0, mode_err}, 48'd1);
    for (int k = 0; k < 6; k++) begin
      beat(32'h1111_0000 * k, k == 0);
      @(negedge clk);
      chk(!out_valid, "R4 silent", {47'd0, out_valid}, 48'd0);
    end
    in_valid = 0;
    cfg_mode = 2'b10;
    @(negedge clk);
    chk(!mode_err, "R4 clear", {47'd0, mode_err}, 48'd0);

    // R8: stray bytes then a framed pair
    idle(1);
    beat(32'h0000_00AB, 1'b0);
    beat(32'h0000_00CD, 1'b0);
    send_part(16'h4321, 16'h8765, 0, 1'b1);
    expect_pair(16'h4321, 16'h8765, "R8 byte resync");
    cfg_mode = 2'b01;
    idle(1);
    beat(32'h0000_0F0F, 1'b0);
    send_part(16'hCAFE, 16'hBEEF, 0, 1'b1);
    expect_pair(16'hCAFE, 16'hBEEF, "R8 word resync");

    // R9: order flip between partial beats (change on an idle cycle)
    cfg_mode = 2'b10;
    idle(1);
    send_part(16'h0102, 16'h0304, 0, 1'b1);
    expect_pair(16'h0102, 16'h0304, "R9 setup");
    beat(32'h0000_0077, 1'b0);
    beat(32'h0000_0066, 1'b0);
    @(negedge clk);
    in_valid = 0; cfg_q_first = 1;
    @(posedge clk);
    send_part(16'h9ABC, 16'hDEF0, 0, 1'b0);
    expect_pair(16'h9ABC, 16'hDEF0, "R9 order change");
    // R9: mode change in the same cycle as the next beat
    cfg_mode = 2'b01; cfg_q_first = 0;
    idle(1);
    beat(32'h0000_1111, 1'b0);
    @(negedge clk);
    cfg_mode = 2'b10; in_valid = 1; in_frame = 0; in_data = 32'h0000_0055;
    @(posedge clk);
    send_part(16'h5566, 16'h7788, 1, 1'b0);
    expect_pair(16'h5566, 16'h7788, "R9 mode change");

    // R10: idle cycles with garbage between byte beats
    idle(1);
    beat(32'h0000_0012, 1'b1);
    idle(3); quiet("R10 gap");
    beat(32'h0000_0034, 1'b0);
    idle(2); quiet("R10 gap");
    beat(32'h0000_0056, 1'b0);
    idle(4); quiet("R10 gap");
    send_part(16'h1234, 16'h5678, 3, 1'b0);
    expect_pair(16'h1234, 16'h5678, "R10 gaps ignored");
    quiet("R10 single strobe");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule